// File: doc/BRIEF.md
# NMI Entry Sequencer

This block watches an active-low, non-maskable interrupt line. It turns each high-to-low transition into a pending request. It then performs the processor's interrupt entry on the next instruction boundary. The line is first brought into the clock domain through a flop chain. A falling edge sets a sticky pending flag. Holding the line low has no further effect.

When the core signals that an instruction has finished and a request is pending, the sequencer captures the current context. The context is the program bank, the program counter, the status byte and the stack pointer. The sequencer writes four context bytes down the stack, one per clock. It then reads the two-byte handler vector from a location chosen by the emulation/native mode. Finally it presents the new program counter with bank zero and the updated stack pointer, and pulses a completion strobe.

The pending flag clears when entry starts. A new falling edge that arrives while an entry is in progress is kept and is serviced afterwards.

Top module: `nmi_entry_seq`

## Requirements
- R1: A falling edge on `nmi_n`, seen after the two-flop synchroniser, sets a pending request. A low level that persists does not create one.
- R2: Entry starts only on a clock edge where the sequencer is idle, a request is pending and `insn_done` is 1. Without `insn_done`, a request waits indefinitely with no bus activity.
- R3: After a falling edge has been serviced, keeping `nmi_n` low causes no further entry, even with `insn_done` held at 1.
- R4: A falling edge that occurs while an entry is in progress is latched. It produces a second complete entry after the first one finishes.
- R5: Each push drives `mem_we`=1 at address {8'h00, SP}, and SP then decrements by one. SP starts from the `sp_in` value captured at entry start and wraps modulo 2^16.
- R6: The four pushed bytes appear in this order: program bank, PC[15:8], PC[7:0], status.
- R7: The vector is read with `mem_re`=1, low byte first and then high byte. The addresses are 24'h00FFFA/24'h00FFFB when `emu_mode` was 1 at entry start, and 24'h00FFEA/24'h00FFEB otherwise. `mem_rdata` is taken in the same cycle that `mem_re` is high.
- R8: On completion, `done` is 1 for exactly one cycle. At that point `new_pc` = {high byte, low byte}, `new_pbr` = 8'h00 and `sp_out` = captured SP − 4. These values hold until the next entry.
- R9: While `rst` is asserted and after it is released, `busy`, `mem_we`, `mem_re` and `done` are 0. `new_pc`, `new_pbr` and `sp_out` are 0, and no request is pending.
- R10: The sequence is fixed. The first push occurs in the cycle after the start edge, the four pushes occupy consecutive cycles, and the two reads follow immediately. `done` comes in the cycle after the high-byte read, seven cycles after the start edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_n | input | 1 | Asynchronous active-low interrupt request |
| insn_done | input | 1 | Instruction boundary strobe from the core |
| emu_mode | input | 1 | 1 = emulation vector, 0 = native vector |
| pbr_in | input | 8 | Current program bank |
| pc_in | input | 16 | Current program counter |
| psr_in | input | 8 | Current status register |
| sp_in | input | 16 | Current stack pointer |
| mem_addr | output | 24 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read data, valid in the cycle `mem_re` is high |
| new_pc | output | 16 | Handler address |
| new_pbr | output | 8 | Program bank after entry (zero) |
| sp_out | output | 16 | Stack pointer after the pushes |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bound checker enforces the bus-level rules on every cycle. Writes stay in bank zero with addresses that step down by one, and reads and writes never overlap. Reads land on the vector page and follow the last push directly. `done` is a single-cycle pulse with bank zero, preceded by a read. The edge-versus-level semantics can only be shown by the bench's scenarios: a line held low, a request waiting for an instruction boundary, and a re-trigger during service. The same applies to the byte order, the vector value chosen by the latched mode, and stack wraparound. In those scenarios a scoreboard compares every write and every completion against values computed from the captured context.

// File: rtl/nmi_pkg.sv
package nmi_pkg;

    localparam int DW         = 8;
    localparam int PCW        = 16;
    localparam int AW         = 24;
    localparam int PUSH_BYTES = 4;
    localparam int IDXW       = $clog2(PUSH_BYTES);

    localparam logic [AW-1:0] VEC_NATIVE_LO = 24'h00FFEA;
    localparam logic [AW-1:0] VEC_EMU_LO    = 24'h00FFFA;
    localparam logic [DW-1:0] STACK_BANK    = 8'h00;
    localparam logic [DW-1:0] HANDLER_BANK  = 8'h00;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PUSH,
        SQ_VLO,
        SQ_VHI,
        SQ_FIN
    } seq_state_e;

    typedef struct packed {
        logic [DW-1:0]  bank;
        logic [PCW-1:0] pc;
        logic [DW-1:0]  psr;
    } cpu_ctx_t;

    // Byte pushed at position idx: bank, PC high, PC low, status.
    function automatic logic [DW-1:0] ctx_byte(cpu_ctx_t c, logic [IDXW-1:0] idx);
        logic [DW-1:0] b;
        case (idx)
            2'd0:    b = c.bank;
            2'd1:    b = c.pc[PCW-1:DW];
            2'd2:    b = c.pc[DW-1:0];
            default: b = c.psr;
        endcase
        return b;
    endfunction

    function automatic logic [AW-1:0] vec_base(logic emu);
        return emu ? VEC_EMU_LO : VEC_NATIVE_LO;
    endfunction

endpackage

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic nmi_n,
    input  logic clr,
    output logic pending
);
    // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
    logic [STAGES:0] chain;
    logic            fall;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-1:0], nmi_n};
    end

    assign fall = chain[STAGES] & ~chain[STAGES-1];

    // A new edge wins over a clear in the same cycle so it is never lost.
    always_ff @(posedge clk) begin
        if (rst)       pending <= 1'b0;
        else if (fall) pending <= 1'b1;
        else if (clr)  pending <= 1'b0;
    end

endmodule

// File: rtl/nmi_bus_drive.sv
module nmi_bus_drive
    import nmi_pkg::*;
(
    input  seq_state_e       state,
    input  cpu_ctx_t         ctx,
    input  logic [PCW-1:0]   sp,
    input  logic [IDXW-1:0]  idx,
    input  logic             emu,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic             mem_we,
    output logic             mem_re
);
    logic [AW-1:0] vbase;

    assign vbase = vec_base(emu);

    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        case (state)
            SQ_PUSH: begin
                mem_we    = 1'b1;
                mem_addr  = {STACK_BANK, sp};
                mem_wdata = ctx_byte(ctx, idx);
            end
            SQ_VLO: begin
                mem_re   = 1'b1;
                mem_addr = vbase;
            end
            SQ_VHI: begin
                mem_re   = 1'b1;
                mem_addr = vbase + AW'(1);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/nmi_entry_fsm.sv
module nmi_entry_fsm
    import nmi_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            pending,
    input  logic            insn_done,
    input  logic            emu_mode,
    input  cpu_ctx_t        ctx_in,
    input  logic [PCW-1:0]  sp_in,
    input  logic [DW-1:0]   rdata,
    output logic            take,
    output seq_state_e      state,
    output cpu_ctx_t        ctx,
    output logic [PCW-1:0]  sp,
    output logic [IDXW-1:0] idx,
    output logic            emu,
    output logic [PCW-1:0]  new_pc,
    output logic [DW-1:0]   new_pbr
);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(PUSH_BYTES - 1);

    logic [DW-1:0] vec_lo;

    assign take = (state == SQ_IDLE) && pending && insn_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            ctx     <= '0;
            sp      <= '0;
            idx     <= '0;
            emu     <= 1'b0;
            vec_lo  <= '0;
            new_pc  <= '0;
            new_pbr <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (take) begin
                        ctx   <= ctx_in;
                        sp    <= sp_in;
                        idx   <= '0;
                        emu   <= emu_mode;
                        state <= SQ_PUSH;
                    end
                end
                SQ_PUSH: begin
                    sp  <= sp - PCW'(1);
                    idx <= idx + IDXW'(1);
                    if (idx == LAST_IDX) state <= SQ_VLO;
                end
                SQ_VLO: begin
                    vec_lo <= rdata;
                    state  <= SQ_VHI;
                end
                SQ_VHI: begin
                    new_pc  <= {rdata, vec_lo};
                    new_pbr <= HANDLER_BANK;
                    state   <= SQ_FIN;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nmi_entry_seq.sv
module nmi_entry_seq
    import nmi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          nmi_n,
    input  logic          insn_done,
    input  logic          emu_mode,
    input  logic [7:0]    pbr_in,
    input  logic [15:0]   pc_in,
    input  logic [7:0]    psr_in,
    input  logic [15:0]   sp_in,
    output logic [23:0]   mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          mem_we,
    output logic          mem_re,
    input  logic [7:0]    mem_rdata,
    output logic [15:0]   new_pc,
    output logic [7:0]    new_pbr,
    output logic [15:0]   sp_out,
    output logic          busy,
    output logic          done
);
    logic            pending;
    logic            take;
    seq_state_e      state;
    cpu_ctx_t        ctx_live;
    cpu_ctx_t        ctx;
    logic [PCW-1:0]  sp;
    logic [IDXW-1:0] idx;
    logic            emu;

    assign ctx_live = '{bank: pbr_in, pc: pc_in, psr: psr_in};

    nmi_edge_latch #(.STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .nmi_n   (nmi_n),
        .clr     (take),
        .pending (pending)
    );

    nmi_entry_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .pending   (pending),
        .insn_done (insn_done),
        .emu_mode  (emu_mode),
        .ctx_in    (ctx_live),
        .sp_in     (sp_in),
        .rdata     (mem_rdata),
        .take      (take),
        .state     (state),
        .ctx       (ctx),
        .sp        (sp),
        .idx       (idx),
        .emu       (emu),
        .new_pc    (new_pc),
        .new_pbr   (new_pbr)
    );

    nmi_bus_drive u_bus (
        .state     (state),
        .ctx       (ctx),
        .sp        (sp),
        .idx       (idx),
        .emu       (emu),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_re    (mem_re)
    );

    assign sp_out = sp;
    assign busy   = (state != SQ_IDLE);
    assign done   = (state == SQ_FIN);

endmodule

// File: rtl/nmi_entry_seq_chk.sv
module nmi_entry_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic [23:0] mem_addr,
    input logic        mem_we,
    input logic        mem_re,
    input logic [7:0]  new_pbr,
    input logic        busy,
    input logic        done
);
    p_we_bank0_r5: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_addr[23:16] == 8'h00);

    p_push_step_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> mem_addr[15:0] == $past(mem_addr[15:0]) - 16'd1);

    p_rw_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    p_read_follows_push_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we) |-> mem_re);

    p_vec_page_r7: assert property (@(posedge clk) disable iff (rst)
        mem_re |-> mem_addr[23:8] == 16'h00FF);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_bank_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> new_pbr == 8'h00);

    p_done_after_read_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(mem_re));

    p_activity_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_re || done) |-> busy);

endmodule

bind nmi_entry_seq nmi_entry_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .new_pbr  (new_pbr),
    .busy     (busy),
    .done     (done)
);

// File: tb/nmi_entry_seq_bench.sv
module nmi_entry_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nmi_n = 1'b1;
    logic        insn_done = 1'b0;
    logic        emu_mode = 1'b0;
    logic [7:0]  pbr_in = '0;
    logic [15:0] pc_in = '0;
    logic [7:0]  psr_in = '0;
    logic [15:0] sp_in = '0;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        mem_re;
    logic [7:0]  mem_rdata;
    logic [15:0] new_pc;
    logic [7:0]  new_pbr;
    logic [15:0] sp_out;
    logic        busy;
    logic        done;

    int n_vec  = 0;
    int n_fail = 0;
    int n_done = 0;
    bit finished = 1'b0;

    logic [31:0] wr_q[$];
    logic [31:0] dn_q[$];

    always #5 clk = ~clk;

    // Vector memory model: combinational read
    always_comb begin
        case (mem_addr)
            24'h00FFFA: mem_rdata = 8'h34;
            24'h00FFFB: mem_rdata = 8'h12;
            24'h00FFEA: mem_rdata = 8'hCD;
            24'h00FFEB: mem_rdata = 8'hAB;
            default:    mem_rdata = 8'hEE;
        endcase
    end

    nmi_entry_seq u_nmi_entry_seq (
        .clk(clk), .rst(rst), .nmi_n(nmi_n), .insn_done(insn_done),
        .emu_mode(emu_mode), .pbr_in(pbr_in), .pc_in(pc_in), .psr_in(psr_in),
        .sp_in(sp_in), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
        .new_pc(new_pc), .new_pbr(new_pbr), .sp_out(sp_out),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver side: queue the writes and completion an entry must produce
    task automatic expect_entry(input logic [7:0] bank, input logic [15:0] pc,
                                input logic [7:0] psr, input logic [15:0] sp,
                                input bit emu);
        wr_q.push_back({8'h00, sp, bank});
        wr_q.push_back({8'h00, sp - 16'd1, pc[15:8]});
        wr_q.push_back({8'h00, sp - 16'd2, pc[7:0]});
        wr_q.push_back({8'h00, sp - 16'd3, psr});
        dn_q.push_back({emu ? 16'h1234 : 16'hABCD, sp - 16'd4});
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_busy();
        for (int i = 0; i < 40 && !busy; i++) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 40 && busy; i++) @(negedge clk);
    endtask

    // Monitor: compares bus writes and completions against the queues
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we) begin
                if (wr_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected write", {mem_addr, mem_wdata}, 32'h0);
                end else begin
                    logic [31:0] e;
                    e = wr_q.pop_front();
                    chk({mem_addr, mem_wdata} == e, "R5/R6 push addr/data", {mem_addr, mem_wdata}, e);
                end
            end
            if (done) begin
                n_done++;
                if (dn_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected done", {new_pc, sp_out}, 32'h0);
                end else begin
                    logic [31:0] e;
                    e = dn_q.pop_front();
                    chk({new_pc, sp_out} == e, "R7/R8 new_pc and sp_out", {new_pc, sp_out}, e);
                    chk(new_pbr == 8'h00, "R8 new_pbr", {24'h0, new_pbr}, 32'h0);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        bit seen;
        cycles(3);
        // R9: state during reset
        chk(!busy && !mem_we && !mem_re && !done, "R9 outputs in reset",
            {28'h0, busy, mem_we, mem_re, done}, 32'h0);
        rst = 1'b0;
        cycles(2);
        chk(!busy && !mem_we && !done && new_pc == 0 && sp_out == 0 && new_pbr == 0,
            "R9 outputs after reset", {new_pc, sp_out}, 32'h0);

        // R1/R2: edge pends but waits for insn_done; native vector
        pbr_in = 8'h12; pc_in = 16'h3456; psr_in = 8'h30; sp_in = 16'h01FF; emu_mode = 1'b0;
        expect_entry(8'h12, 16'h3456, 8'h30, 16'h01FF, 1'b0);
        nmi_n = 1'b0;
        cycles(10);
        chk(!busy, "R2 no entry without insn_done", {31'h0, busy}, 32'h0);
        insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0;
        chk(busy, "R1/R10 entry starts after edge and boundary", {31'h0, busy}, 32'h1);
        n = 0;
        while (!done && n < 20) begin @(negedge clk); n++; end
        chk(n == 6, "R10 done seven cycles after start", n, 6);
        cycles(2);

        // R3: held low, no re-entry
        insn_done = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (busy) seen = 1'b1;
        end
        insn_done = 1'b0;
        chk(!seen, "R3 held-low level ignored", {31'h0, seen}, 32'h0);

        // R7: emulation vector, mode latched at start
        nmi_n = 1'b1;
        cycles(4);
        pbr_in = 8'h7E; pc_in = 16'hC0DE; psr_in = 8'h04; sp_in = 16'h0100; emu_mode = 1'b1;
        expect_entry(8'h7E, 16'hC0DE, 8'h04, 16'h0100, 1'b1);
        insn_done = 1'b1;
        nmi_n = 1'b0;
        wait_busy();
        emu_mode = 1'b0;
        insn_done = 1'b0;
        wait_idle();
        chk(new_pc == 16'h1234 && sp_out == 16'h00FC, "R7 emulation vector held",
            {new_pc, sp_out}, {16'h1234, 16'h00FC});

        // R4: re-trigger during service
        nmi_n = 1'b1;
        cycles(4);
        pbr_in = 8'h01; pc_in = 16'h8001; psr_in = 8'hA5; sp_in = 16'h1FFF; emu_mode = 1'b0;
        expect_entry(8'h01, 16'h8001, 8'hA5, 16'h1FFF, 1'b0);
        expect_entry(8'h01, 16'h8001, 8'hA5, 16'h1FFF, 1'b0);
        n = n_done;
        insn_done = 1'b1;
        nmi_n = 1'b0;
        wait_busy();
        nmi_n = 1'b1;
        cycles(3);
        nmi_n = 1'b0;
        cycles(25);
        insn_done = 1'b0;
        chk(n_done - n == 2, "R4 edge during service gives second entry", n_done - n, 2);

        // R5: stack pointer wrap
        nmi_n = 1'b1;
        cycles(4);
        pbr_in = 8'hFF; pc_in = 16'h0000; psr_in = 8'h01; sp_in = 16'h0001;
        expect_entry(8'hFF, 16'h0000, 8'h01, 16'h0001, 1'b0);
        insn_done = 1'b1;
        nmi_n = 1'b0;
        wait_busy();
        insn_done = 1'b0;
        wait_idle();
        chk(sp_out == 16'hFFFD, "R5 stack wraps", sp_out, 16'hFFFD);

        cycles(3);
        chk(wr_q.size() == 0, "R6 all pushes observed", wr_q.size(), 0);
        chk(dn_q.size() == 0, "R8 all completions observed", dn_q.size(), 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule